// File: doc/BRIEF.md
# Working Register Address Translator

This block turns the register operands of an 8-bit processor into physical register-file addresses. The register space holds 256 byte locations in sixteen groups of sixteen. A 4-bit working-register operand resolves through register pointers. The pointers work either as one 16-register window or as two independent 8-register windows. An 8-bit direct operand passes through unchanged, but it is checked against the group that may only be reached through the windows. When the resolved location falls in the top group, the block also reports the selected page, because that group is a paged window onto up to 64 banks of sixteen registers.

The block holds two pointers and a page selector. Each pointer stores a block number, where a block is 8 registers and 32 blocks cover the space. The pointers and the page selector are loaded by four commands. The command that was used last decides whether working operands map through one wide window or two narrow ones. Each lookup is registered and appears one clock after the operand is presented. The storage array, the instruction decoder and the ALU sit outside this block.

Top module: `wra_translator`

## Requirements
- R1: After a synchronous reset, `res_valid` is 0 and the window mode is single. Both pointers and the page selector are 0, so working operand rN resolves to address N with page 0.
- R2: After a set-single command (`cmd_op` = 0, block number in `cmd_data[4:0]`), a working operand resolves to {block[4:1], operand[3:0]}. An odd block number therefore behaves like the even block below it.
- R3: After a set-pointer-0 (`cmd_op` = 1) or set-pointer-1 (`cmd_op` = 2) command, the mode is twin. A working operand with bit 3 clear resolves to {pointer0, operand[2:0]}. A working operand with bit 3 set resolves to {pointer1, operand[2:0]}.
- R4: A pointer command changes only the pointer it names. A set-single command loads pointer 0 and leaves pointer 1 unchanged, and it returns the block to single mode.
- R5: A direct access (`acc_direct` = 1) returns `acc_operand[7:0]` unchanged as the address.
- R6: `res_illegal` is 1 exactly when a direct address lies in 208 to 223. A working access is never illegal, even when it resolves into that range.
- R7: When the resolved address lies in 240 to 255, `res_page` carries the current page selector. For any other address, `res_page` is 0.
- R8: A set-page command (`cmd_op` = 3, page in `cmd_data[5:0]`) keeps its page until the next set-page command. It changes neither pointer nor the mode.
- R9: The result of an access appears one clock after `acc_valid`. A command that arrives in the same cycle as an access affects only later accesses.
- R10: `res_valid` is 1 in the cycle after an access and 0 in the cycle after a cycle with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Pointer or page command strobe |
| cmd_op | input | 2 | 0 set single, 1 set pointer 0, 2 set pointer 1, 3 set page |
| cmd_data | input | 6 | Block number [4:0] or page [5:0] |
| acc_valid | input | 1 | Operand lookup strobe |
| acc_direct | input | 1 | 1 direct 8-bit address, 0 working operand in [3:0] |
| acc_operand | input | 8 | Operand to translate |
| res_valid | output | 1 | Registered result valid |
| res_addr | output | 8 | Physical register address |
| res_page | output | 6 | Page for the paged group, otherwise 0 |
| res_illegal | output | 1 | Direct access into the window-only group |

## Verification
The bench builds the block with its default parameters: 8-bit addresses, 4-bit working operands, 32 blocks and 64 pages. This size is small enough to sweep completely. Every block number is tried with every working operand in single mode, and 32 pointer pairs with all operands in twin mode. Every direct address is tried, and every page value is tried through both direct and working access to the paged group. The expected addresses, illegal flags and pages are worked out arithmetically from the bench's own record of the commands it issued.

// File: rtl/wra_pkg.sv
package wra_pkg;

  typedef enum logic [1:0] {
    CMD_SET_SINGLE = 2'd0,
    CMD_SET_PTR0   = 2'd1,
    CMD_SET_PTR1   = 2'd2,
    CMD_SET_PAGE   = 2'd3
  } ptr_cmd_e;

  typedef enum logic {
    WIN_SINGLE = 1'b0,
    WIN_TWIN   = 1'b1
  } win_mode_e;

endpackage

// File: rtl/wra_ptr_bank.sv
module wra_ptr_bank
  import wra_pkg::*;
#(
  parameter int BLK_W  = 5,
  parameter int PAGE_W = 6,
  parameter int CMD_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [CMD_W-1:0]  cmd_data,
  output win_mode_e         mode,
  output logic [BLK_W-1:0]  ptr0,
  output logic [BLK_W-1:0]  ptr1,
  output logic [PAGE_W-1:0] page
);

  ptr_cmd_e op_q;
  assign op_q = ptr_cmd_e'(cmd_op);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= WIN_SINGLE;
      ptr0 <= '0;
      ptr1 <= '0;
      page <= '0;
    end else if (cmd_valid) begin
      case (op_q)
        CMD_SET_SINGLE: begin
          mode <= WIN_SINGLE;
          ptr0 <= cmd_data[BLK_W-1:0];
        end
        CMD_SET_PTR0: begin
          mode <= WIN_TWIN;
          ptr0 <= cmd_data[BLK_W-1:0];
        end
        CMD_SET_PTR1: begin
          mode <= WIN_TWIN;
          ptr1 <= cmd_data[BLK_W-1:0];
        end
        default: page <= cmd_data[PAGE_W-1:0];
      endcase
    end
  end

endmodule

// File: rtl/wra_window_map.sv
module wra_window_map
  import wra_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OPND_W = 4,
  parameter int BLK_W  = ADDR_W - OPND_W + 1
) (
  input  win_mode_e         mode,
  input  logic [BLK_W-1:0]  ptr0,
  input  logic [BLK_W-1:0]  ptr1,
  input  logic [OPND_W-1:0] opnd,
  output logic [ADDR_W-1:0] phys
);

  localparam int HALF_W = OPND_W - 1;

  logic [ADDR_W-1:0] single_addr;
  logic [ADDR_W-1:0] twin_addr;
  logic [BLK_W-1:0]  twin_blk;

  // wide window: drop pointer lsb, full operand as offset
  assign single_addr = {ptr0[BLK_W-1:1], opnd};

  // narrow windows: operand msb picks the pointer
  assign twin_blk  = opnd[OPND_W-1] ? ptr1 : ptr0;
  assign twin_addr = {twin_blk, opnd[HALF_W-1:0]};

  always_comb begin
    if (mode == WIN_TWIN) phys = twin_addr;
    else                  phys = single_addr;
  end

endmodule

// File: rtl/wra_region_check.sv
module wra_region_check #(
  parameter int ADDR_W      = 8,
  parameter int OPND_W      = 4,
  parameter int PAGE_W      = 6,
  parameter int WINONLY_GRP = 13,
  parameter int PAGED_GRP   = 15
) (
  input  logic [ADDR_W-1:0] phys,
  input  logic              direct,
  input  logic [PAGE_W-1:0] page,
  output logic              illegal,
  output logic [PAGE_W-1:0] page_out
);

  localparam int GRP_W = ADDR_W - OPND_W;
  localparam logic [GRP_W-1:0] WINONLY_IDX = GRP_W'(WINONLY_GRP);
  localparam logic [GRP_W-1:0] PAGED_IDX   = GRP_W'(PAGED_GRP);

  logic [GRP_W-1:0] grp;
  assign grp = phys[ADDR_W-1:OPND_W];

  assign illegal  = direct && (grp == WINONLY_IDX);
  assign page_out = (grp == PAGED_IDX) ? page : '0;

endmodule

// File: rtl/wra_translator.sv
module wra_translator
  import wra_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int OPND_W      = 4,
  parameter int PAGE_W      = 6,
  parameter int WINONLY_GRP = 13,
  parameter int PAGED_GRP   = 15,
  localparam int BLK_W      = ADDR_W - OPND_W + 1,
  localparam int CMD_W      = (PAGE_W > BLK_W) ? PAGE_W : BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              acc_valid,
  input  logic              acc_direct,
  input  logic [ADDR_W-1:0] acc_operand,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_addr,
  output logic [PAGE_W-1:0] res_page,
  output logic              res_illegal
);

  win_mode_e         mode;
  logic [BLK_W-1:0]  ptr0, ptr1;
  logic [PAGE_W-1:0] page;
  logic [ADDR_W-1:0] win_addr;
  logic [ADDR_W-1:0] phys;
  logic              illegal_c;
  logic [PAGE_W-1:0] page_c;

  wra_ptr_bank #(
    .BLK_W(BLK_W), .PAGE_W(PAGE_W), .CMD_W(CMD_W)
  ) bank_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .mode(mode), .ptr0(ptr0), .ptr1(ptr1), .page(page)
  );

  wra_window_map #(
    .ADDR_W(ADDR_W), .OPND_W(OPND_W), .BLK_W(BLK_W)
  ) map_i (
    .mode(mode), .ptr0(ptr0), .ptr1(ptr1),
    .opnd(acc_operand[OPND_W-1:0]), .phys(win_addr)
  );

  assign phys = acc_direct ? acc_operand : win_addr;

  wra_region_check #(
    .ADDR_W(ADDR_W), .OPND_W(OPND_W), .PAGE_W(PAGE_W),
    .WINONLY_GRP(WINONLY_GRP), .PAGED_GRP(PAGED_GRP)
  ) region_i (
    .phys(phys), .direct(acc_direct), .page(page),
    .illegal(illegal_c), .page_out(page_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_addr    <= '0;
      res_page    <= '0;
      res_illegal <= 1'b0;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        res_addr    <= phys;
        res_page    <= page_c;
        res_illegal <= illegal_c;
      end
    end
  end

endmodule

// File: rtl/wra_translator_chk.sv
module wra_translator_chk #(
  parameter int ADDR_W      = 8,
  parameter int OPND_W      = 4,
  parameter int PAGE_W      = 6,
  parameter int WINONLY_GRP = 13,
  parameter int PAGED_GRP   = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_direct,
  input logic [ADDR_W-1:0] acc_operand,
  input logic              res_valid,
  input logic [ADDR_W-1:0] res_addr,
  input logic [PAGE_W-1:0] res_page,
  input logic              res_illegal
);

  localparam int GRP_W = ADDR_W - OPND_W;
  localparam logic [GRP_W-1:0] WINONLY_IDX = GRP_W'(WINONLY_GRP);
  localparam logic [GRP_W-1:0] PAGED_IDX   = GRP_W'(PAGED_GRP);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !res_valid);                                        // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> res_valid);                                   // R10

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !res_valid);                                 // R10

  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_direct) |=> res_addr == $past(acc_operand)); // R5

  AST_WORKING_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_direct) |=> !res_illegal);               // R6

  AST_ILLEGAL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_illegal) |-> res_addr[ADDR_W-1:OPND_W] == WINONLY_IDX); // R6

  AST_PAGE_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_addr[ADDR_W-1:OPND_W] != PAGED_IDX) |-> res_page == '0); // R7

endmodule

bind wra_translator wra_translator_chk #(
  .ADDR_W(ADDR_W), .OPND_W(OPND_W), .PAGE_W(PAGE_W),
  .WINONLY_GRP(WINONLY_GRP), .PAGED_GRP(PAGED_GRP)
) chk_i (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_direct(acc_direct),
  .acc_operand(acc_operand), .res_valid(res_valid), .res_addr(res_addr),
  .res_page(res_page), .res_illegal(res_illegal)
);

// File: tb/wra_translator_tb.sv
`timescale 1ns/1ps
module wra_translator_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [5:0] cmd_data = 6'd0;
  logic       acc_valid = 1'b0;
  logic       acc_direct = 1'b0;
  logic [7:0] acc_operand = 8'd0;
  logic       res_valid;
  logic [7:0] res_addr;
  logic [5:0] res_page;
  logic       res_illegal;

  int checks = 0;
  int errors = 0;

  // bench record of commanded state
  bit       m_twin = 1'b0;
  bit [4:0] m_p0 = 5'd0;
  bit [4:0] m_p1 = 5'd0;
  bit [5:0] m_pg = 6'd0;

  always #4 clk = ~clk;

  wra_translator dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .acc_valid(acc_valid), .acc_direct(acc_direct),
    .acc_operand(acc_operand), .res_valid(res_valid), .res_addr(res_addr),
    .res_page(res_page), .res_illegal(res_illegal)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_addr(input bit dir, input int opnd);
    if (dir) return opnd;
    if (!m_twin) return (int'(m_p0 >> 1) << 4) | (opnd & 15);
    if (opnd & 8) return (int'(m_p1) << 3) | (opnd & 7);
    return (int'(m_p0) << 3) | (opnd & 7);
  endfunction

  // caller is at a falling edge
  task automatic cmd(input int op, input int data);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_data = 6'(data);
    @(negedge clk);
    cmd_valid = 1'b0;
    case (op)
      0: begin m_twin = 1'b0; m_p0 = 5'(data); end
      1: begin m_twin = 1'b1; m_p0 = 5'(data); end
      2: begin m_twin = 1'b1; m_p1 = 5'(data); end
      default: m_pg = 6'(data);
    endcase
  endtask

  task automatic access(input string req, input bit dir, input int opnd);
    int a;
    a = exp_addr(dir, opnd);
    acc_valid = 1'b1; acc_direct = dir; acc_operand = 8'(opnd);
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, res_valid, 1);
    check(req, res_addr, a);
    check(req, res_illegal, (dir && a >= 208 && a <= 223) ? 1 : 0);
    check(req, res_page, (a >= 240) ? m_pg : 0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 valid", res_valid, 0);
    check("R1 addr", res_addr, 0);
    access("R1 r5 after reset", 1'b0, 5);
    access("R1 r15 after reset", 1'b0, 15);

    // R10 idle cycle gives no valid
    @(negedge clk);
    check("R10 idle", res_valid, 0);

    // R2 single mode, every block and operand
    for (int b = 0; b < 32; b++) begin
      cmd(0, b);
      for (int r = 0; r < 16; r++) access("R2 single", 1'b0, r);
    end
    cmd(0, 3);
    access("R2 odd block 3 r0", 1'b0, 0);
    check("R2 block3 r0=16", res_addr, 16);

    // R3 twin mode sweep
    for (int a = 0; a < 32; a++) begin
      cmd(1, a);
      cmd(2, (a * 7 + 3) % 32);
      for (int r = 0; r < 16; r++) access("R3 twin", 1'b0, r);
    end

    // R4 pointer independence and return to single
    cmd(1, 3); cmd(2, 7);
    cmd(2, 9);
    access("R4 ptr1 leaves ptr0", 1'b0, 2);
    check("R4 r2 in block3", res_addr, 26);
    cmd(1, 20);
    access("R4 ptr0 leaves ptr1", 1'b0, 9);
    check("R4 r9 in block9", res_addr, 73);
    cmd(0, 6);
    access("R4 single restores", 1'b0, 12);
    check("R4 single r12", res_addr, 60);
    cmd(1, 1);
    access("R4 ptr1 kept over single", 1'b0, 8);
    check("R4 r8 in block9", res_addr, 72);

    // R5 R6 R7 every direct address with a nonzero page
    cmd(3, 45);
    for (int d = 0; d < 256; d++) access("R5 R6 R7 direct", 1'b1, d);

    // R6 working access into the window-only group is legal
    cmd(0, 26);
    access("R6 working into 208..223", 1'b0, 4);
    check("R6 addr 212", res_addr, 212);
    check("R6 not illegal", res_illegal, 0);

    // R7 R8 every page through direct and working access
    cmd(0, 30);
    for (int p = 0; p < 64; p++) begin
      cmd(3, p);
      access("R7 R8 page direct", 1'b1, 240 + (p % 16));
      access("R7 R8 page working", 1'b0, p % 16);
    end
    // R8 page command leaves mode and pointers alone
    cmd(3, 17);
    access("R8 pointers kept", 1'b0, 1);
    check("R8 r1 addr 241", res_addr, 241);
    check("R8 page 17", res_page, 17);

    // R9 command and access in the same cycle
    cmd(0, 2);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = 6'd10;
    acc_valid = 1'b1; acc_direct = 1'b0; acc_operand = 8'd3;
    @(negedge clk);
    cmd_valid = 1'b0; acc_valid = 1'b0;
    check("R9 old pointer used", res_addr, 19);
    m_twin = 1'b0; m_p0 = 5'd10;
    access("R9 new pointer next", 1'b0, 3);
    check("R9 new pointer addr", res_addr, 83);

    // R10 valid drops after last access
    @(negedge clk);
    check("R10 drop", res_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule